// File: doc/BRIEF.md
# Flash Program and Erase Host Sequencer

This block sits on the host side of a byte-wide parallel flash bus and runs one write operation for each accepted request. It supports three kinds of operation: byte program, sector erase and chip erase. For each one it issues the unlock and command write cycles that the flash needs. It then reads a status location over and over until the flash reports that the operation has finished, and it signals the outcome with a one-cycle `done` or `err` pulse.

The request side uses a valid/ready handshake and carries an operation code, a target address, a data byte and a polling-mode select. The bus side presents an address, write data and read data, plus one active-high strobe for writes and one for reads. The number of clocks each strobe stays active is a parameter.

Completion is accepted only after three consecutive consistent status reads: the first consistent read plus two confirmation reads. A read that happens to catch the moment of completion therefore cannot end the operation on its own. A parameterised poll budget turns a flash that never finishes into an error.

Top module: `flash_op_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `bus_we`, `bus_re`, `done` and `err` are 0.
- R2: Operation code 0 (program) issues four writes, in this order: address 5555h data AAh, address 2AAAh data 55h, address 5555h data A0h, then the target address with the request data byte.
- R3: Operation code 1 (sector erase) issues six writes, in this order: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then data 30h at the target address with its low `SECT_W` bits cleared.
- R4: Operation code 2 (chip erase) issues the same first five writes as R3, then data 10h at address 5555h.
- R5: Each bus cycle holds its strobe high for exactly `STROBE_CYC` clocks and is followed by exactly one clock with both strobes low. Address and write data stay steady while the strobe is high. Read data is captured in the last clock of the read strobe. `bus_we` and `bus_re` are never high together.
- R6: In toggle mode (`req_mode`=0), a status read counts as consistent when its bit 6 equals bit 6 of the previous status read of the same operation. The first status read is never consistent.
- R7: In complement mode (`req_mode`=1), a status read counts as consistent when its bit 7 equals bit 7 of the request data (program) or equals 1 (either erase).
- R8: Completion requires three consecutive consistent reads. An inconsistent read resets the run to zero, so one lucky read followed by a failed confirmation does not complete the operation.
- R9: If `MAX_POLLS` status reads pass without completion, `err` pulses. When the read that completes the operation is also read number `MAX_POLLS`, `done` wins.
- R10: `done` and `err` are each high for exactly one clock, in the clock after the gap that follows the last status read. `req_ready` is high again in that same clock.
- R11: While an operation is running, `req_ready` is low and a request held on `req_valid` has no effect on the bus cycles or the outcome.
- R12: Operation code 3 is accepted, causes no bus cycle, and pulses `err` in the clock after acceptance.
- R13: Status reads use the target address for program and chip erase, and the sector base address (low `SECT_W` bits cleared) for sector erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, able to accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_mode | input | 1 | Status polling: 0 toggle bit 6, 1 complement bit 7 |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on timeout or invalid operation |
| bus_addr | output | ADDR_W | Flash address, valid while a strobe is high |
| bus_wdata | output | 8 | Flash write data, valid while `bus_we` is high |
| bus_rdata | input | 8 | Flash read data |
| bus_we | output | 1 | Write strobe, active high |
| bus_re | output | 1 | Read strobe, active high |

## Verification
The first write strobe appears in the clock after the request is accepted. Every bus cycle after that takes `STROBE_CYC` strobe clocks plus one gap clock. The `done` or `err` pulse comes in the clock after the gap of the final status read; for operation code 3 it comes in the clock after acceptance. The bench turns each request into a queue of expected per-clock bus states, one entry per clock, using its own table of command cycles and its own walk over the scripted flash replies. It pops and compares one entry at every falling edge, so a bus cycle or a pulse that arrives one clock early or late shows up as a mismatch.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WR   = 3'd1,
    S_WGAP = 3'd2,
    S_RD   = 3'd3,
    S_RGAP = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic        use_tgt_addr;
    logic        use_tgt_data;
    logic [14:0] a;
    logic [7:0]  d;
  } cmd_word_t;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  function automatic logic [2:0] op_writes(input op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

  // One command step of the unlock/command sequence for the given operation.
  function automatic cmd_word_t cmd_step(input op_e op, input logic [2:0] idx);
    cmd_word_t w;
    w = '{use_tgt_addr: 1'b0, use_tgt_data: 1'b0, a: UNLOCK_A, d: 8'hAA};
    case (idx)
      3'd0: begin w.a = UNLOCK_A; w.d = 8'hAA; end
      3'd1: begin w.a = UNLOCK_B; w.d = 8'h55; end
      3'd2: begin w.a = UNLOCK_A; w.d = (op == OP_PROG) ? 8'hA0 : 8'h80; end
      3'd3: begin
        if (op == OP_PROG) begin
          w.use_tgt_addr = 1'b1;
          w.use_tgt_data = 1'b1;
        end else begin
          w.a = UNLOCK_A; w.d = 8'hAA;
        end
      end
      3'd4: begin w.a = UNLOCK_B; w.d = 8'h55; end
      default: begin
        if (op == OP_SECT) begin
          w.use_tgt_addr = 1'b1;
          w.d = 8'h30;
        end else begin
          w.a = UNLOCK_A; w.d = 8'h10;
        end
      end
    endcase
    return w;
  endfunction

  // Whether one status byte is consistent with completion.
  function automatic logic poll_ok(input logic use_dpoll, input logic have_prev,
                                   input logic prev6, input logic [7:0] b,
                                   input logic exp7);
    if (use_dpoll) return b[7] == exp7;
    return have_prev && (b[6] == prev6);
  endfunction

endpackage

// File: rtl/fseq_strobe_timer.sv
module fseq_strobe_timer #(
  parameter int STROBE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(STROBE_CYC) + 1;
  localparam logic [CW-1:0] LAST_V = CW'(STROBE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != LAST_V) cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == LAST_V);
endmodule

// File: rtl/fseq_poll_eval.sv
module fseq_poll_eval
  import flash_seq_pkg::*;
#(
  parameter int CONFIRM_N = 2,
  localparam int NEED = CONFIRM_N + 1,
  localparam int SW = $clog2(NEED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic [7:0]    rdata,
  input  logic          use_dpoll,
  input  logic          exp7,
  output logic          complete,
  output logic [SW-1:0] streak
);
  localparam logic [SW-1:0] NEED_V = SW'(NEED);

  logic          have_q, prev6_q;
  logic [SW-1:0] streak_q;
  logic          ok;

  assign ok = poll_ok(use_dpoll, have_q, prev6_q, rdata, exp7);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_q   <= 1'b0;
      prev6_q  <= 1'b0;
      streak_q <= '0;
    end else if (sample) begin
      have_q   <= 1'b1;
      prev6_q  <= rdata[6];
      if (!ok) streak_q <= '0;
      else if (streak_q != NEED_V) streak_q <= streak_q + 1'b1;
    end
  end

  assign complete = (streak_q == NEED_V);
  assign streak   = streak_q;
endmodule

// File: rtl/fseq_poll_limit.sv
module fseq_poll_limit #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] MAX_V = CW'(MAX_POLLS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (sample && cnt_q != MAX_V) cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted = (cnt_q == MAX_V);
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SECT_W     = 12,
  parameter int STROBE_CYC = 3,
  parameter int MAX_POLLS  = 16,
  parameter int CONFIRM_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_mode,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              bus_we,
  output logic              bus_re
);
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_W;
  localparam int SW = $clog2(CONFIRM_N + 2);

  seq_st_e           st_q;
  op_e               op_q;
  logic [2:0]        idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              mode_q;
  logic              done_q, err_q;

  // Named internal events for the checker
  logic          strobe_last;
  logic          seq_sample;
  logic          poll_clear;
  logic          seq_complete;
  logic          seq_exhausted;
  logic [SW-1:0] seq_streak;

  cmd_word_t         cmd;
  logic [ADDR_W-1:0] tgt_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              exp7;

  assign seq_sample = (st_q == S_RD) && strobe_last;
  assign poll_clear = (st_q == S_WGAP);
  assign exp7       = (op_q == OP_PROG) ? data_q[7] : 1'b1;

  fseq_strobe_timer #(.STROBE_CYC(STROBE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run((st_q == S_WR) || (st_q == S_RD)),
    .last(strobe_last)
  );

  fseq_poll_eval #(.CONFIRM_N(CONFIRM_N)) u_eval (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear), .sample(seq_sample),
    .rdata(bus_rdata), .use_dpoll(mode_q), .exp7(exp7),
    .complete(seq_complete), .streak(seq_streak)
  );

  fseq_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear), .sample(seq_sample),
    .exhausted(seq_exhausted)
  );

  always_comb begin
    cmd      = cmd_step(op_q, idx_q);
    tgt_addr = (op_q == OP_SECT) ? (addr_q & SECT_MASK) : addr_q;
    wr_addr  = cmd.use_tgt_addr ? tgt_addr : ADDR_W'(cmd.a);
    wr_data  = cmd.use_tgt_data ? data_q : cmd.d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_PROG;
      idx_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          mode_q <= req_mode;
          idx_q  <= '0;
          if (op_e'(req_op) == OP_BAD) err_q <= 1'b1;
          else st_q <= S_WR;
        end
        S_WR: if (strobe_last) st_q <= S_WGAP;
        S_WGAP: begin
          if (idx_q == op_writes(op_q) - 3'd1) st_q <= S_RD;
          else begin
            idx_q <= idx_q + 3'd1;
            st_q  <= S_WR;
          end
        end
        S_RD: if (strobe_last) st_q <= S_RGAP;
        S_RGAP: begin
          if (seq_complete) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (seq_exhausted) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else st_q <= S_RD;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign bus_we    = (st_q == S_WR);
  assign bus_re    = (st_q == S_RD);
  assign bus_addr  = bus_we ? wr_addr : (bus_re ? tgt_addr : '0);
  assign bus_wdata = bus_we ? wr_data : 8'h00;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int ADDR_W     = 18,
  parameter int STROBE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              done,
  input logic              err,
  input logic              seq_complete
);
  logic       strb;
  logic [7:0] run_len_q;

  assign strb = bus_we || bus_re;

  always_ff @(posedge clk) begin
    if (!rst_n || !strb) run_len_q <= '0;
    else if (run_len_q != 8'hFF) run_len_q <= run_len_q + 8'd1;
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

  assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb && run_len_q != 8'd0) |-> (run_len_q == 8'(STROBE_CYC)));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> !req_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(seq_complete));

  assert_bad_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd3) |=> (err && !bus_we && !bus_re));
endmodule

bind flash_op_seq fseq_checker #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_fseq_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .done(done), .err(err),
  .seq_complete(seq_complete)
);

// File: tb/flash_op_seq_bench.sv
module flash_op_seq_bench;
  localparam int CLK_NS = 10;
  localparam int AW     = 18;
  localparam int STB    = 3;
  localparam int MAXP   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic          req_mode = 1'b0;
  logic          done, err;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = 8'h00;
  logic          bus_we, bus_re;

  always #(CLK_NS/2) clk = ~clk;

  flash_op_seq #(.ADDR_W(AW), .SECT_W(12), .STROBE_CYC(STB), .MAX_POLLS(MAXP)) u_flash_op_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode),
    .done(done), .err(err), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_we(bus_we), .bus_re(bus_re)
  );

  typedef struct {
    bit we, re, rdy, dn, er;
    logic [AW-1:0] a;
    logic [7:0] d;
    string tag;
  } cyc_t;

  cyc_t       expq[$];
  logic [7:0] scr [0:31];
  int         rcount = 0;
  bit         prev_re = 0;
  int         total = 0;
  int         bad = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(bit we, bit re, bit rdy, bit dn, bit er,
                      logic [AW-1:0] a, logic [7:0] d, string tag);
    cyc_t e;
    e.we = we; e.re = re; e.rdy = rdy; e.dn = dn; e.er = er;
    e.a = a; e.d = d; e.tag = tag;
    expq.push_back(e);
  endtask

  // Per-clock comparison at the falling edge, then the flash reply update.
  task automatic tick(string idle_tag);
    cyc_t e;
    @(negedge clk);
    if (expq.size() > 0) e = expq.pop_front();
    else begin
      e.we = 0; e.re = 0; e.rdy = 1; e.dn = 0; e.er = 0;
      e.a = '0; e.d = '0; e.tag = idle_tag;
    end
    check(e.tag, "we/re/ready/done/err", {27'd0, bus_we, bus_re, req_ready, done, err},
          {27'd0, e.we, e.re, e.rdy, e.dn, e.er});
    if (e.we || e.re) check(e.tag, "addr", 32'(bus_addr), 32'(e.a));
    if (e.we) check(e.tag, "wdata", 32'(bus_wdata), 32'(e.d));
    if (prev_re && !bus_re) begin
      rcount++;
      bus_rdata = scr[rcount % 32];
    end
    prev_re = bus_re;
  endtask

  task automatic fill(logic [7:0] v);
    for (int i = 0; i < 32; i++) scr[i] = v;
  endtask

  // Build the expected per-clock trace of one request.
  task automatic plan_op(int op, logic [AW-1:0] addr, logic [7:0] data, bit mode,
                         string wtag, string endtag);
    logic [AW-1:0] wa [6];
    logic [7:0]    wd [6];
    logic [AW-1:0] base;
    int nw, r, streak;
    bit havep, p6, ok, fin, dn;
    logic [7:0] b;
    if (op == 3) begin
      push(0, 0, 1, 0, 1, '0, '0, endtag);
      push(0, 0, 1, 0, 0, '0, '0, "R10");
      return;
    end
    base = (op == 1) ? {addr[AW-1:12], 12'h000} : addr;
    wa[0] = 18'h05555; wd[0] = 8'hAA;
    wa[1] = 18'h02AAA; wd[1] = 8'h55;
    if (op == 0) begin
      nw = 4;
      wa[2] = 18'h05555; wd[2] = 8'hA0;
      wa[3] = addr;      wd[3] = data;
      wa[4] = '0; wd[4] = '0; wa[5] = '0; wd[5] = '0;
    end else begin
      nw = 6;
      wa[2] = 18'h05555; wd[2] = 8'h80;
      wa[3] = 18'h05555; wd[3] = 8'hAA;
      wa[4] = 18'h02AAA; wd[4] = 8'h55;
      if (op == 1) begin wa[5] = base; wd[5] = 8'h30; end
      else begin wa[5] = 18'h05555; wd[5] = 8'h10; end
    end
    for (int k = 0; k < nw; k++) begin
      for (int s = 0; s < STB; s++) push(1, 0, 0, 0, 0, wa[k], wd[k], wtag);
      push(0, 0, 0, 0, 0, '0, '0, "R5");
    end
    r = 0; streak = 0; havep = 0; p6 = 0; fin = 0; dn = 0;
    while (!fin) begin
      b = scr[r % 32];
      if (mode) ok = (b[7] == ((op == 0) ? data[7] : 1'b1));
      else ok = havep && (b[6] == p6);
      p6 = b[6]; havep = 1;
      streak = ok ? streak + 1 : 0;
      for (int s = 0; s < STB; s++) push(0, 1, 0, 0, 0, base, '0, "R13");
      push(0, 0, 0, 0, 0, '0, '0, "R5");
      r++;
      if (streak == 3) begin fin = 1; dn = 1; end
      else if (r == MAXP) fin = 1;
    end
    push(0, 0, 1, dn, !dn, '0, '0, endtag);
    push(0, 0, 1, 0, 0, '0, '0, "R10");
  endtask

  task automatic run_op(int op, logic [AW-1:0] addr, logic [7:0] data, bit mode,
                        string wtag, string endtag, bit noise);
    int n;
    tick("R1");
    req_valid = 1; req_op = 2'(op); req_addr = addr; req_data = data; req_mode = mode;
    rcount = 0; bus_rdata = scr[0];
    plan_op(op, addr, data, mode, wtag, endtag);
    tick("R1");
    req_valid = 0;
    n = 0;
    while (expq.size() > 0) begin
      tick("R11");
      n++;
      if (noise && n == 4) begin
        req_valid = 1; req_op = 2'd0; req_addr = 18'h3FFFF; req_data = 8'h00; req_mode = 1;
      end
      if (noise && n == 24) req_valid = 0;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    fill(8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle state after reset
    repeat (3) tick("R1");

    // R2 and R6: program, toggle polling, completes on read 7
    fill(8'h00);
    scr[0] = 8'h40; scr[1] = 8'h00; scr[2] = 8'h40; scr[3] = 8'h00;
    run_op(0, 18'h1_2345, 8'h3C, 0, "R2", "R6", 0);

    // R8: complement polling with a failed confirmation in the middle
    fill(8'h5A);
    scr[0] = 8'hA5; scr[2] = 8'hDA;
    run_op(0, 18'h0_0777, 8'h5A, 1, "R2", "R8", 0);

    // R3, R7, R13: sector erase, complement polling at the sector base
    fill(8'hFF);
    scr[0] = 8'h00; scr[1] = 8'h00;
    run_op(1, 18'h2_3456, 8'h00, 1, "R3", "R7", 0);

    // R4 and R11: chip erase, toggle polling, request held on while busy
    fill(8'h40);
    run_op(2, 18'h0_1000, 8'h00, 0, "R4", "R11", 1);

    // R9: bit 6 never stops toggling, so the poll budget runs out
    for (int i = 0; i < 32; i++) scr[i] = (i % 2 == 0) ? 8'h40 : 8'h00;
    run_op(0, 18'h0_0010, 8'h11, 0, "R2", "R9", 0);

    // R9: completion on the last budgeted read beats the timeout
    fill(8'h00);
    scr[13] = 8'h80; scr[14] = 8'h80; scr[15] = 8'h80;
    run_op(0, 18'h1_0000, 8'h80, 1, "R2", "R9", 0);

    // R12: invalid operation code
    run_op(3, 18'h0_0000, 8'h00, 0, "R12", "R12", 0);

    repeat (3) tick("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule